// File: doc/BRIEF.md
# Serial Configuration Target with Bulk Save and Restore

This block is a two-wire serial target that exposes a bank of byte-wide configuration registers to a bus controller. The controller writes a register pointer and then streams data bytes into consecutive registers, or sets the pointer and reads consecutive registers back. The pointer advances by one after every byte moved in either direction. The register contents drive the rest of the chip through a flat parallel port.

Two reserved byte values, sent as the only data byte of a write frame, request a bulk copy. One copies the whole bank into an external non-volatile store. The other loads the bank back from that store. The copy starts once the frame's STOP is seen. It moves one byte per store handshake, from register 0 upwards. While a copy runs, the target does not acknowledge its own address. While a load from the store runs, a flag tells the clock outputs to stay off. A load from the store also runs automatically after reset, before the target acknowledges any frame.

Both bus lines are sampled on a system clock that runs at least eight times faster than the serial clock. The target pulls the data line low through an open-drain enable.

Top module: `nvcfg_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 1101010 (byte 0xD4 for a write, 0xD5 for a read). For every other address it leaves the data line released for the whole frame.
- R2: In a write frame, the first data byte that is not a command code sets the register pointer. Each later byte is stored at the pointer, and the pointer then advances by one, until the STOP.
- R3: A read frame returns the register at the pointer and advances the pointer after each byte. The read frame may follow the pointer-setting write either after a STOP and a new START, or after a repeated START.
- R4: Reading an address at or above the bank size returns 0x00. Writing such an address changes no register, but the pointer still advances.
- R5: The command code 0xFE, sent as the first data byte of a write frame, starts a save once the frame's STOP is seen. The save writes registers 0 to N-1 into the store in ascending order, one byte per handshake, each with the value the register holds.
- R6: The command code 0xFF starts a load in the same way. The load writes every register from the store in ascending order. The outputs-off flag is high exactly while a load is running.
- R7: While a save or load runs, the target does not acknowledge its address. Once the copy has finished, it acknowledges again.
- R8: After reset, the target loads every register from the store before it acknowledges its first address, and the outputs-off flag is high during that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as sampled from the pad |
| sdaIn | input | 1 | Serial data line as sampled from the pad |
| sdaOe | output | 1 | When high, the pad pulls the data line low |
| cfgRegs | output | 8*NUM_REGS | Register bank contents, register i in bits [8i+7:8i] |
| storeReq | output | 1 | Store access request, held until storeDone |
| storeWe | output | 1 | 1 = write to the store (save), 0 = read from it (load) |
| storeAddr | output | 8 | Store byte address |
| storeWdata | output | 8 | Byte being saved |
| storeRdata | input | 8 | Byte returned by the store, valid with storeDone |
| storeDone | input | 1 | One-cycle pulse that completes the current access |
| outputsOff | output | 1 | Forces the clock outputs off while a load runs |

## Verification
The two functions that overlap are the bulk copy and a new address phase. The bench sends an address frame right after reset, while the automatic load is still running. It also sends one right after the STOP of a save command and one right after the STOP of a load command. Each of these frames must be refused while a store model with a long handshake latency keeps the copy running. A repeat of the same frame after the store goes quiet must be acknowledged. During every copy, a monitor checks the order of the store addresses, the bytes written to the store, and the outputs-off flag on each cycle.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;

  localparam int PtrW = 8;

  typedef enum logic [2:0] {
    BusIdle,
    BusAddr,
    BusAddrAck,
    BusWrite,
    BusWrAck,
    BusRead,
    BusRdAck
  } busState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic            rxShift;
    logic            rxBit;
    logic            setPtr;
    logic            wrReg;
    logic            loadTx;
    logic            shiftTx;
    logic            seqLoad;
    logic [PtrW-1:0] seqIdx;
  } dpCtl_t;

endpackage

// File: rtl/nvcfg_dp.sv
module nvcfg_dp
  import nvcfg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic [7:0]            storeRdata,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [7:0]            storeWdata,
  output logic [8*NUM_REGS-1:0] cfgRegs
);

  localparam logic [PtrW-1:0] LastIdx = PtrW'(NUM_REGS - 1);

  logic [7:0]      regs [NUM_REGS];
  logic [PtrW-1:0] ptr;
  logic [7:0]      txByte;
  logic            ptrValid;
  logic [7:0]      ptrData;

  assign ptrValid = (ptr <= LastIdx);

  always_comb begin
    ptrData    = 8'h00;
    storeWdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PtrW'(i))        ptrData    = regs[i];
      if (ctl.seqIdx == PtrW'(i)) storeWdata = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      rxByte <= '0;
      txByte <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (ctl.rxShift) rxByte <= {rxByte[6:0], ctl.rxBit};
      if (ctl.setPtr)  ptr    <= rxByte;
      if (ctl.wrReg || ctl.loadTx) ptr <= ptr + 1'b1;
      if (ctl.loadTx)  txByte <= ptrValid ? ptrData : 8'h00;
      else if (ctl.shiftTx) txByte <= {txByte[6:0], 1'b0};
      for (int i = 0; i < NUM_REGS; i++) begin
        if (ctl.wrReg && ptr == PtrW'(i))         regs[i] <= rxByte;
        if (ctl.seqLoad && ctl.seqIdx == PtrW'(i)) regs[i] <= storeRdata;
      end
    end
  end

  assign txMsb = txByte[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfgRegs[g*8 +: 8] = regs[g];
  end

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrReg |=> (ptr == $past(ptr) + 1'b1));

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadTx && !ptrValid) |=> (txByte == 8'h00));

endmodule

// File: rtl/nvcfg_ctrl.sv
module nvcfg_ctrl
  import nvcfg_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] TARGET_ADDR = 7'b1101010,
  parameter logic [7:0] CMD_SAVE    = 8'hFE,
  parameter logic [7:0] CMD_LOAD    = 8'hFF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic [7:0]      rxByte,
  input  logic            txMsb,
  input  logic            storeDone,
  output dpCtl_t          ctl,
  output logic            sdaOe,
  output logic            storeReq,
  output logic            storeWe,
  output logic [PtrW-1:0] storeAddr,
  output logic            outputsOff
);

  localparam logic [PtrW-1:0] LastIdx = PtrW'(NUM_REGS - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow   = sclSync[SYNC_STAGES-1];
  assign sdaNow   = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclNow && !sclPrev;
  assign sclFall  = !sclNow && sclPrev;
  assign startDet = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopDet  = sclNow && sclPrev && !sdaPrev && sdaNow;

  busState_t       busState, nState;
  logic [3:0]      bitCnt, nBit;
  logic            rwBit, nRw, firstByte, nFirst;
  logic            pendSave, nPendS, pendLoad, nPendL;
  logic            seqActive, nSeqAct, seqLoadMode, nSeqMode;
  logic [PtrW-1:0] seqIdx, nIdx;
  dpCtl_t          ctlC;

  always_comb begin
    ctlC        = '0;
    ctlC.rxBit  = sdaNow;
    ctlC.seqIdx = seqIdx;
    nState   = busState;
    nBit     = bitCnt;
    nRw      = rwBit;
    nFirst   = firstByte;
    nPendS   = pendSave;
    nPendL   = pendLoad;
    nSeqAct  = seqActive;
    nSeqMode = seqLoadMode;
    nIdx     = seqIdx;

    // bulk copy sequencer: one byte per store handshake
    if (seqActive && storeDone) begin
      ctlC.seqLoad = seqLoadMode;
      if (seqIdx == LastIdx) nSeqAct = 1'b0;
      else nIdx = seqIdx + 1'b1;
    end

    if (startDet) begin
      nState = BusAddr;
      nBit   = '0;
      nPendS = 1'b0;
      nPendL = 1'b0;
    end else if (stopDet) begin
      nState = BusIdle;
      nPendS = 1'b0;
      nPendL = 1'b0;
      if ((pendSave || pendLoad) && !seqActive) begin
        nSeqAct  = 1'b1;
        nSeqMode = pendLoad;
        nIdx     = '0;
      end
    end else begin
      unique case (busState)
        BusAddr: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctlC.rxShift = 1'b1;
            nBit = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (rxByte[7:1] == TARGET_ADDR && !seqActive) begin
              nState = BusAddrAck;
              nRw    = rxByte[0];
              nFirst = 1'b1;
            end else begin
              nState = BusIdle;
            end
          end
        end
        BusAddrAck: begin
          if (sclFall) begin
            nBit = '0;
            if (rwBit) begin
              nState      = BusRead;
              ctlC.loadTx = 1'b1;
            end else begin
              nState = BusWrite;
            end
          end
        end
        BusWrite: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctlC.rxShift = 1'b1;
            nBit = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nState = BusWrAck;
            if (firstByte) begin
              nFirst = 1'b0;
              if (rxByte == CMD_SAVE)      nPendS = 1'b1;
              else if (rxByte == CMD_LOAD) nPendL = 1'b1;
              else ctlC.setPtr = 1'b1;
            end else if (!pendSave && !pendLoad) begin
              ctlC.wrReg = 1'b1;
            end
          end
        end
        BusWrAck: begin
          if (sclFall) begin
            nBit   = '0;
            nState = BusWrite;
          end
        end
        BusRead: begin
          if (sclRise && bitCnt < 4'd8) begin
            nBit = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              nState = BusRdAck;
              nBit   = '0;
            end else begin
              ctlC.shiftTx = 1'b1;
            end
          end
        end
        BusRdAck: begin
          if (sclRise) begin
            if (sdaNow) nState = BusIdle;
            else nBit = 4'd1;
          end else if (sclFall && bitCnt == 4'd1) begin
            nState      = BusRead;
            nBit        = '0;
            ctlC.loadTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState    <= BusIdle;
      bitCnt      <= '0;
      rwBit       <= 1'b0;
      firstByte   <= 1'b0;
      pendSave    <= 1'b0;
      pendLoad    <= 1'b0;
      seqActive   <= 1'b1;   // power-up load
      seqLoadMode <= 1'b1;
      seqIdx      <= '0;
    end else begin
      busState    <= nState;
      bitCnt      <= nBit;
      rwBit       <= nRw;
      firstByte   <= nFirst;
      pendSave    <= nPendS;
      pendLoad    <= nPendL;
      seqActive   <= nSeqAct;
      seqLoadMode <= nSeqMode;
      seqIdx      <= nIdx;
    end
  end

  assign ctl        = ctlC;
  assign sdaOe      = (busState == BusAddrAck) || (busState == BusWrAck) ||
                      ((busState == BusRead) && !txMsb);
  assign storeReq   = seqActive;
  assign storeWe    = !seqLoadMode;
  assign storeAddr  = seqIdx;
  assign outputsOff = seqActive && seqLoadMode;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busState == BusIdle) |-> !sdaOe);

  p_addr_walk_r5: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && storeDone && storeAddr != LastIdx) |=>
      (storeReq && storeAddr == $past(storeAddr) + 1'b1));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && !storeDone) |=> (storeReq && $stable(storeAddr) && $stable(storeWe)));

  p_off_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    outputsOff |-> (storeReq && !storeWe));

  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busState == BusAddrAck) |-> !seqActive);

endmodule

// File: rtl/nvcfg_target.sv
module nvcfg_target
  import nvcfg_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] TARGET_ADDR = 7'b1101010,
  parameter logic [7:0] CMD_SAVE    = 8'hFE,
  parameter logic [7:0] CMD_LOAD    = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [8*NUM_REGS-1:0] cfgRegs,
  output logic                  storeReq,
  output logic                  storeWe,
  output logic [7:0]            storeAddr,
  output logic [7:0]            storeWdata,
  input  logic [7:0]            storeRdata,
  input  logic                  storeDone,
  output logic                  outputsOff
);

  dpCtl_t     ctl;
  logic [7:0] rxByte;
  logic       txMsb;

  nvcfg_ctrl #(
    .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES), .TARGET_ADDR(TARGET_ADDR),
    .CMD_SAVE(CMD_SAVE), .CMD_LOAD(CMD_LOAD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .storeDone(storeDone),
    .ctl(ctl), .sdaOe(sdaOe), .storeReq(storeReq), .storeWe(storeWe),
    .storeAddr(storeAddr), .outputsOff(outputsOff)
  );

  nvcfg_dp #(.NUM_REGS(NUM_REGS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .storeRdata(storeRdata),
    .rxByte(rxByte), .txMsb(txMsb), .storeWdata(storeWdata), .cfgRegs(cfgRegs)
  );

endmodule

// File: tb/nvcfg_target_tb_top.sv
module nvcfg_target_tb_top;

  localparam int NREG = 16;
  localparam int LAT  = 30;
  localparam int QTR  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, storeReq, storeWe, storeDone, outputsOff;
  logic [8*NREG-1:0] cfgRegs;
  logic [7:0] storeAddr, storeWdata, storeRdata;
  logic sdaBus;

  int errors = 0, checks = 0;
  int monErr = 0, saveSeen = 0, lat = 0;
  logic [7:0] mem [NREG];
  logic [7:0] model [NREG];

  always #2.5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  nvcfg_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .cfgRegs(cfgRegs), .storeReq(storeReq), .storeWe(storeWe),
    .storeAddr(storeAddr), .storeWdata(storeWdata), .storeRdata(storeRdata),
    .storeDone(storeDone), .outputsOff(outputsOff)
  );

  // store model with a fixed handshake latency
  always @(posedge clk) begin
    if (!rstN) begin
      storeDone  <= 1'b0;
      storeRdata <= 8'h00;
      lat        <= 0;
      for (int i = 0; i < NREG; i++) mem[i] <= 8'(i * 29 + 7);
    end else begin
      storeDone <= 1'b0;
      if (storeReq && !storeDone) begin
        if (lat == LAT - 1) begin
          lat       <= 0;
          storeDone <= 1'b1;
          if (storeWe) mem[storeAddr[3:0]] <= storeWdata;
          else storeRdata <= mem[storeAddr[3:0]];
        end else lat <= lat + 1;
      end
    end
  end

  // R5/R6 monitor: save order and data, outputs-off flag
  always @(negedge clk) begin
    if (rstN) begin
      if (storeDone && storeWe) begin
        if (storeAddr != 8'(saveSeen % NREG)) monErr++;
        if (storeWdata != model[storeAddr[3:0]]) monErr++;
        saveSeen++;
      end
      if (outputsOff != (storeReq && !storeWe)) monErr++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(posedge clk);
    #1;
  endtask

  task automatic bStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic bStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); ack = ~sdaBus; sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); b[i] = sdaBus; sclM = 1'b0;
    end
    waitQ(); sdaM = ~ackIt; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ(); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed * 37 + k * 13 + 5);
  endfunction

  task automatic probeAddr(input logic [6:0] a, output logic ack);
    bStart(); sendByte({a, 1'b0}, ack); bStop(); waitQ();
  endtask

  task automatic wrBurst(input logic [7:0] p, input int n, input int seed);
    logic ack;
    bStart();
    sendByte(8'hD4, ack); chk("R1 write address ack", ack, 1);
    sendByte(p, ack);     chk("R2 pointer ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(pat(seed, k), ack);
      if (int'(p) + k < NREG) model[int'(p) + k] = pat(seed, k);
    end
    bStop(); waitQ();
  endtask

  task automatic rdBurst(input logic [7:0] p, input int n, input logic useRestart);
    logic ack;
    logic [7:0] b;
    bStart();
    sendByte(8'hD4, ack);
    sendByte(p, ack);
    if (!useRestart) bStop();
    bStart();
    sendByte(8'hD5, ack); chk("R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      readByte(k != n - 1, b);
      if (int'(p) + k < NREG) chk("R3 read data", b, model[int'(p) + k]);
      else chk("R4 unimplemented read is zero", b, 8'h00);
    end
    bStop(); waitQ();
  endtask

  task automatic cmpRegs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, cfgRegs[i*8 +: 8], model[i]);
  endtask

  task automatic waitCopy();
    while (storeReq) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    repeat (10) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R8 outputs off at reset exit", outputsOff, 1);
    chk("R8 data line released at reset", sdaOe, 0);
    for (int i = 0; i < NREG; i++) model[i] = 8'(i * 29 + 7);
    // R8/R7: address during the power-up load is refused
    probeAddr(7'b1101010, ack);
    chk("R8 no ack during power-up load", ack, 0);
    waitCopy();
    chk("R8 outputs off cleared", outputsOff, 0);
    cmpRegs("R8 registers loaded from store");
    probeAddr(7'b1101010, ack);
    chk("R7 ack after load done", ack, 1);

    // R1: sweep every address
    for (int a = 0; a < 128; a++) begin
      probeAddr(7'(a), ack);
      chk("R1 address match", ack, (a == 7'b1101010) ? 1 : 0);
    end

    // R2/R3/R4: bursts from every start pointer, some running past the bank
    for (int p = 0; p < NREG; p++) begin
      wrBurst(8'(p), 3, p + 1);
      rdBurst(8'(p), 3, p[0]);
    end
    cmpRegs("R2 register port after bursts");
    wrBurst(8'h40, 2, 99);
    cmpRegs("R4 unimplemented write ignored");
    rdBurst(8'h40, 2, 1'b1);
    rdBurst(8'h0E, 4, 1'b0);

    // R5 save, with an address probe during the copy (R7)
    saveSeen = 0;
    bStart(); sendByte(8'hD4, ack); sendByte(8'hFE, ack); bStop();
    probeAddr(7'b1101010, ack);
    chk("R7 no ack during save", ack, 0);
    waitCopy();
    chk("R5 bytes saved", saveSeen, NREG);
    for (int i = 0; i < NREG; i++) chk("R5 store content", mem[i], model[i]);
    probeAddr(7'b1101010, ack);
    chk("R7 ack after save", ack, 1);

    // R6 load: overwrite the bank, then bring back the saved image
    for (int i = 0; i < NREG; i++) model[i] = mem[i];
    wrBurst(8'h00, NREG, 55);
    chk("R2 bank overwritten", cfgRegs[7:0], pat(55, 0));
    for (int i = 0; i < NREG; i++) model[i] = mem[i];
    bStart(); sendByte(8'hD4, ack); sendByte(8'hFF, ack); bStop();
    repeat (4) @(posedge clk);
    #1 chk("R6 outputs off during load", outputsOff, 1);
    probeAddr(7'b1101010, ack);
    chk("R7 no ack during load", ack, 0);
    waitCopy();
    chk("R6 outputs off cleared", outputsOff, 0);
    cmpRegs("R6 registers after load");
    rdBurst(8'h00, NREG, 1'b1);
    chk("R5 R6 copy monitor errors", monErr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule